// File: doc/BRIEF.md
# Eight-Operation Combinational ALU

This block is a purely combinational arithmetic-logic unit. It takes two operands of a parameterised width, 8 bits by default, and a 3-bit operation code, and returns one result of the same width. It has no clock, no storage, no flags and no carry output. When any input changes, the result follows in the same time step.

The eight operations are wrapping add, wrapping subtract, signed less-than, two logical shifts, and bitwise XOR, OR and AND. Each shift takes its amount from the low bits of the second operand and ignores the rest of that operand. The block can serve as the execute stage of a small datapath. The caller registers the result wherever it is needed.

Top module: `alu_core`

## Requirements
- R1: The operation code selects the function as follows: 3'd0 add, 3'd1 shift left, 3'd2 signed less-than, 3'd3 subtract, 3'd4 XOR, 3'd5 shift right, 3'd6 OR, 3'd7 AND.
- R2: Add returns (a + b) modulo 2^W and reports no overflow. With the default width, 127 + 1 gives 8'h80.
- R3: Subtract returns (a - b) modulo 2^W. With the default width, -128 - 1 gives 8'h7F.
- R4: Shift left moves a toward the MSB by b[2:0] places, drops the bits that leave the top and puts zeros in the vacated low bits.
- R5: Shift right moves a toward the LSB by b[2:0] places and puts zeros in the vacated high bits, including when a is negative.
- R6: For both shifts, b[7:3] has no effect on the result.
- R7: Signed less-than gives 8'h01 when a < b in two's complement, and 8'h00 otherwise. For example, a = 8'hFF and b = 8'h01 give 8'h01.
- R8: For XOR, OR and AND, bit i of the result depends only on bit i of a and bit i of b.
- R9: The result depends only on the present inputs. A change on any input appears at the output without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 8 | First operand, and the value that is shifted |
| b | input | 8 | Second operand; its low 3 bits are the shift amount |
| op | input | 3 | Operation code |
| res | output | 8 | Result |

## Verification
On every input change, the assertions check these properties:
- The operation decode is one-hot.
- Add and subtract are inverses of each other through b.
- The vacated bit at the fill end of each shift is zero, and a shift never adds set bits.
- The less-than result is false when the two operands are equal.
- The XOR, AND and OR outputs agree with one another.

Only the bench's scenarios can show the rest:
- The opcode mapping itself.
- The exact wrap values at the signed limits.
- That the upper bits of b are ignored during shifts.
- That the output follows the inputs with no clock.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

  localparam int OP_W    = 3;
  localparam int NUM_OPS = 1 << OP_W;

  // Codes are fixed: software and decoders depend on them (R1)
  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SLL = 3'd1,
    OP_SLT = 3'd2,
    OP_SUB = 3'd3,
    OP_XOR = 3'd4,
    OP_SRL = 3'd5,
    OP_OR  = 3'd6,
    OP_AND = 3'd7
  } alu_op_e;

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         lt
);

  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x - y;
  endfunction

  // Sign-extend both operands by one bit; the sign of the wide difference is the answer
  function automatic logic f_slt(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] d;
    d = {x[W-1], x} - {y[W-1], y};
    return d[W];
  endfunction

  assign sum  = f_add(a, b);
  assign diff = f_sub(a, b);
  assign lt   = f_slt(a, b);

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_ADD_INVERTS: assert (W'(sum - b) == a) else $error("add not invertible");   // R2
      AST_SUB_INVERTS: assert (W'(diff + b) == a) else $error("sub not invertible");  // R3
      if (a == b) begin
        AST_SLT_EQUAL: assert (!lt) else $error("equal operands compare less");      // R7
      end
    end
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int W   = 8,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   sll,
  output logic [W-1:0]   srl
);

  logic [W-1:0] lstage [SHW+1];
  logic [W-1:0] rstage [SHW+1];

  assign lstage[0] = a;
  assign rstage[0] = a;

  // Log-depth barrel: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign lstage[k+1] = amt[k] ? {lstage[k][W-1-S:0], {S{1'b0}}} : lstage[k];
    assign rstage[k+1] = amt[k] ? {{S{1'b0}}, rstage[k][W-1:S]}   : rstage[k];
  end

  assign sll = lstage[SHW];
  assign srl = rstage[SHW];

  always_comb begin
    if (!$isunknown({a, amt}) && amt != '0) begin
      AST_SLL_FILL: assert (sll[0] == 1'b0) else $error("left shift fill not zero");      // R4
      AST_SRL_FILL: assert (srl[W-1] == 1'b0) else $error("right shift fill not zero");   // R5
      AST_SLL_POP:  assert ($countones(sll) <= $countones(a)) else $error("sll adds ones"); // R4
      AST_SRL_POP:  assert ($countones(srl) <= $countones(a)) else $error("srl adds ones"); // R5
    end
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] x_xor,
  output logic [W-1:0] x_or,
  output logic [W-1:0] x_and
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x_xor[i] = a[i] ^ b[i];
    assign x_or[i]  = a[i] | b[i];
    assign x_and[i] = a[i] & b[i];
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_LOGIC_DISJOINT: assert ((x_xor & x_and) == '0) else $error("xor/and overlap"); // R8
      AST_LOGIC_COVER:    assert ((x_xor | x_and) == x_or) else $error("xor|and != or"); // R8
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    res
);

  localparam int SHW = $clog2(W);

  logic [W-1:0]       sum, diff, sll, srl, x_xor, x_or, x_and;
  logic               lt;
  logic [NUM_OPS-1:0] sel;
  logic [W-1:0]       by_op [NUM_OPS];

  alu_arith_unit #(.W(W)) u_arith (
    .a(a), .b(b), .sum(sum), .diff(diff), .lt(lt)
  );

  alu_shift_unit #(.W(W), .SHW(SHW)) u_shift (
    .a(a), .amt(b[SHW-1:0]), .sll(sll), .srl(srl)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a(a), .b(b), .x_xor(x_xor), .x_or(x_or), .x_and(x_and)
  );

  assign by_op[OP_ADD] = sum;
  assign by_op[OP_SLL] = sll;
  assign by_op[OP_SLT] = {{(W-1){1'b0}}, lt};
  assign by_op[OP_SUB] = diff;
  assign by_op[OP_XOR] = x_xor;
  assign by_op[OP_SRL] = srl;
  assign by_op[OP_OR]  = x_or;
  assign by_op[OP_AND] = x_and;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_dec
    assign sel[i] = (op == OP_W'(i));
  end

  // AND-OR select: every path assigned, no storage
  always_comb begin
    res = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      res |= {W{sel[i]}} & by_op[i];
    end
  end

  always_comb begin
    if (!$isunknown(op)) begin
      AST_SEL_ONEHOT: assert ($onehot(sel)) else $error("decode not one-hot"); // R1
    end
    if (!$isunknown({a, b, op}) && op == OP_SLT) begin
      AST_SLT_SHAPE: assert (res[W-1:1] == '0) else $error("slt upper bits set"); // R7
    end
  end

endmodule

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

  logic       clk = 1'b0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic [2:0] op = '0;
  logic [7:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz, used only to pace the stimulus

  alu_core #(.W(8)) u0 (.a(a), .b(b), .op(op), .res(res));

  // Reference written from the requirement text, using integer arithmetic
  function automatic int model(input int o, input int x, input int y);
    int sx, sy, amt;
    sx  = (x > 127) ? x - 256 : x;
    sy  = (y > 127) ? y - 256 : y;
    amt = y % 8;
    case (o)
      0: return (sx + sy + 512) % 256;
      1: return (x * (1 << amt)) % 256;
      2: return (sx < sy) ? 1 : 0;
      3: return (sx - sy + 512) % 256;
      4: return x ^ y;
      5: return x / (1 << amt);
      6: return x | y;
      default: return x & y;
    endcase
  endfunction

  task automatic apply(input int o, input int x, input int y);
    @(negedge clk);
    op = o[2:0]; a = x[7:0]; b = y[7:0];
    #1;
  endtask

  task automatic check(input string req, input int exp);
    checks++;
    if (res !== exp[7:0]) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               req, op, a, b, res, exp[7:0]);
    end
  endtask

  task automatic run(input string req, input int o, input int x, input int y);
    apply(o, x, y);
    check(req, model(o, x, y));
  endtask

  task automatic t_idle;  // all-zero inputs give zero
    apply(0, 0, 0);
    check("R9", 0);
  endtask

  task automatic t_opcode_map;  // R1: one operand pair, every code
    for (int o = 0; o < 8; o++) run("R1", o, 8'h6C, 8'h35);
  endtask

  task automatic t_add_wrap;  // R2
    apply(0, 127, 1);    check("R2", 8'h80);
    apply(0, 255, 1);    check("R2", 8'h00);
    apply(0, 128, 128);  check("R2", 8'h00);
  endtask

  task automatic t_sub_wrap;  // R3
    apply(3, 128, 1);    check("R3", 8'h7F);
    apply(3, 0, 1);      check("R3", 8'hFF);
    apply(3, 127, 255);  check("R3", 8'h80);
  endtask

  task automatic t_sll;  // R4
    apply(1, 8'hB5, 0);  check("R4", 8'hB5);
    apply(1, 8'hFF, 7);  check("R4", 8'h80);
    apply(1, 8'h81, 1);  check("R4", 8'h02);
  endtask

  task automatic t_srl;  // R5
    apply(5, 8'h80, 7);  check("R5", 8'h01);
    apply(5, 8'hFF, 4);  check("R5", 8'h0F);
    apply(5, 8'hB5, 0);  check("R5", 8'hB5);
  endtask

  task automatic t_shift_upper;  // R6
    apply(1, 8'h03, 8'hF9);  check("R6", 8'h06);
    apply(5, 8'hC0, 8'h0E);  check("R6", 8'h03);
    apply(1, 8'h5A, 8'hF8);  check("R6", 8'h5A);
    apply(5, 8'h5A, 8'h88);  check("R6", 8'h5A);
  endtask

  task automatic t_slt;  // R7
    apply(2, 8'hFF, 8'h01);  check("R7", 1);
    apply(2, 8'h01, 8'hFF);  check("R7", 0);
    apply(2, 8'h80, 8'h7F);  check("R7", 1);
    apply(2, 8'h7F, 8'h7F);  check("R7", 0);
    apply(2, 8'h00, 8'h01);  check("R7", 1);
  endtask

  task automatic t_bitwise;  // R8
    apply(4, 8'hF0, 8'h3C);  check("R8", 8'hCC);
    apply(6, 8'hF0, 8'h0C);  check("R8", 8'hFC);
    apply(7, 8'hF0, 8'h3C);  check("R8", 8'h30);
  endtask

  task automatic t_no_clock;  // R9: output follows inputs between edges
    @(posedge clk);
    #1;
    op = 3'd0; a = 8'd20; b = 8'd22;
    #1;
    check("R9", 42);
    a = 8'd100;
    #1;
    check("R9", 122);
  endtask

  task automatic t_corners;  // every code over the signed limits
    int vals [5] = '{0, 1, 255, 127, 128};
    for (int o = 0; o < 8; o++)
      foreach (vals[i])
        foreach (vals[j]) run("R1", o, vals[i], vals[j]);
  endtask

  task automatic t_random;
    for (int n = 0; n < 1000; n++)
      run("R1", $urandom_range(7), $urandom_range(255), $urandom_range(255));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_opcode_map();
    t_add_wrap();
    t_sub_wrap();
    t_sll();
    t_srl();
    t_shift_upper();
    t_slt();
    t_bitwise();
    t_no_clock();
    t_corners();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule